// File: doc/BRIEF.md
# Packet Stream Switch Fabric

The block is a crossbar for packetised streams. A configurable number of input ports each feed beats of data, a final-beat flag and a metadata flag under a valid/ready handshake. A configurable number of output ports deliver those beats to downstream consumers. Each consumer also drives a room signal that says it can take a whole new packet. A small register port sets, for every input, which output it feeds and whether it is enabled.

Every output has its own round-robin arbiter. It grants one requesting input at a packet boundary, and only while that output's consumer shows room. The grant is then held until the final beat of the packet has been accepted. Beats pass through unchanged, the metadata flag included, so that header or trailer beats need no special handling. The grant fixes the path of a packet, so a route written while a packet is moving only applies from the next packet on that input.

Top module: `pkt_xbar`

## Requirements
- R1: A beat moves only when valid and ready are both high on its output. The input sees ready high in that same cycle, and data, last and meta arrive unchanged.
- R2: After reset every route is disabled, every output valid is low and every input ready is low.
- R3: A configuration write with `cfg_we` high selects the input by `cfg_addr`. Bit DSTW of `cfg_wdata` is the enable and bits DSTW-1:0 are the destination output index. A write to an address of N_IN or more changes no route.
- R4: An input that is disabled, or whose destination index is N_OUT or more, keeps ready low and forwards nothing.
- R5: An idle output grants an input only in a cycle where its room signal is high. While room stays low, no packet starts on it.
- R6: Once an output is granted, it carries only that input's beats, with no other input's beats interleaved, until the last beat is accepted.
- R7: A route written while an input is mid-packet does not move that packet. The new route applies from the input's next packet.
- R8: Among inputs that keep requesting one output, grants rotate in ascending cyclic order, starting after the input served last.
- R9: Every packet arrives complete and in its original beat order at the output that was configured when it was granted. Packets from one input keep their order.
- R10: An input is granted to at most one output at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | IW | Input index being written |
| cfg_wdata | input | DSTW+1 | {enable, destination index} |
| in_data | input | N_IN*DW | Input beat data, one DW slice per input |
| in_valid | input | N_IN | Input beat valid |
| in_last | input | N_IN | Input final-beat flag |
| in_meta | input | N_IN | Input metadata flag |
| in_ready | output | N_IN | Input backpressure |
| out_data | output | N_OUT*DW | Output beat data |
| out_valid | output | N_OUT | Output beat valid |
| out_last | output | N_OUT | Output final-beat flag |
| out_meta | output | N_OUT | Output metadata flag |
| out_ready | input | N_OUT | Consumer accepts beat |
| out_room | input | N_OUT | Consumer has room for a new packet |

## Verification
The bench builds the fabric with three inputs, three outputs and 16-bit data. With three inputs the round-robin pointer has to wrap at a count that is not a power of two. With three outputs and a 2-bit destination field, the value 3 is a real invalid destination, and address 3 is a real out-of-range register. The 16-bit data carries the source input, packet number and beat number, so each delivered beat can be traced to its origin, checked for order, and matched against the output it was expected on.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  // index width that is never zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pxb_route_regs.sv
module pxb_route_regs #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int IW   = pxb_pkg::idx_w(N_IN),
  localparam int DSTW = pxb_pkg::idx_w(N_OUT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [IW-1:0]              cfg_addr,
  input  logic [DSTW:0]              cfg_wdata,
  output logic [N_IN-1:0]            route_ok,
  output logic [N_IN-1:0][DSTW-1:0]  route_dst
);
  localparam logic [DSTW:0] NOUT_V = (DSTW+1)'(N_OUT);

  for (genvar i = 0; i < N_IN; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        route_ok[i]  <= 1'b0;
        route_dst[i] <= '0;
      end else if (cfg_we && cfg_addr == IW'(i)) begin
        route_ok[i]  <= cfg_wdata[DSTW] &&
                        ({1'b0, cfg_wdata[DSTW-1:0]} < NOUT_V);
        route_dst[i] <= cfg_wdata[DSTW-1:0];
      end
    end
  end
endmodule

// File: rtl/pxb_out_arb.sv
module pxb_out_arb #(
  parameter int N_IN = 4,
  localparam int IW  = pxb_pkg::idx_w(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] req,
  input  logic            room,
  input  logic            done,
  output logic            busy,
  output logic [IW-1:0]   owner
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] pick;
  logic          pick_vld;

  // search starts one past the input served last
  always_comb begin
    pick_vld = 1'b0;
    pick     = '0;
    for (int k = 1; k <= N_IN; k++) begin
      int cand;
      cand = int'(ptr) + k;
      if (cand >= N_IN) cand = cand - N_IN;
      if (!pick_vld && req[cand]) begin
        pick_vld = 1'b1;
        pick     = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= IW'(N_IN - 1);
    end else if (busy) begin
      if (done) busy <= 1'b0;
    end else if (room && pick_vld) begin
      busy  <= 1'b1;
      owner <= pick;
      ptr   <= pick;
    end
  end
endmodule

// File: rtl/pkt_xbar.sv
module pkt_xbar #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DW    = 32,
  localparam int IW   = pxb_pkg::idx_w(N_IN),
  localparam int DSTW = pxb_pkg::idx_w(N_OUT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [IW-1:0]             cfg_addr,
  input  logic [DSTW:0]             cfg_wdata,
  input  logic [N_IN-1:0][DW-1:0]   in_data,
  input  logic [N_IN-1:0]           in_valid,
  input  logic [N_IN-1:0]           in_last,
  input  logic [N_IN-1:0]           in_meta,
  output logic [N_IN-1:0]           in_ready,
  output logic [N_OUT-1:0][DW-1:0]  out_data,
  output logic [N_OUT-1:0]          out_valid,
  output logic [N_OUT-1:0]          out_last,
  output logic [N_OUT-1:0]          out_meta,
  input  logic [N_OUT-1:0]          out_ready,
  input  logic [N_OUT-1:0]          out_room
);
  logic [N_IN-1:0]            route_ok;
  logic [N_IN-1:0][DSTW-1:0]  route_dst;
  logic [N_OUT-1:0]           arb_busy;
  logic [N_OUT-1:0][IW-1:0]   arb_owner;
  logic [N_OUT-1:0][N_IN-1:0] arb_req;
  logic [N_OUT-1:0]           arb_done;
  logic [N_IN-1:0]            in_owned;

  pxb_route_regs #(.N_IN(N_IN), .N_OUT(N_OUT)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .route_ok(route_ok), .route_dst(route_dst)
  );

  // which inputs already hold a grant somewhere, and their ready
  always_comb begin
    in_owned = '0;
    in_ready = '0;
    for (int o = 0; o < N_OUT; o++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (arb_busy[o] && arb_owner[o] == IW'(i)) begin
          in_owned[i] = 1'b1;
          in_ready[i] = out_ready[o];
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      for (int i = 0; i < N_IN; i++) begin
        arb_req[o][i] = in_valid[i] && route_ok[i] && !in_owned[i] &&
                        route_dst[i] == DSTW'(o);
      end
    end
  end

  // output side: mux of the owning input
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      out_valid[o] = 1'b0;
      out_data[o]  = '0;
      out_last[o]  = 1'b0;
      out_meta[o]  = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (arb_busy[o] && arb_owner[o] == IW'(i)) begin
          out_valid[o] = in_valid[i];
          out_data[o]  = in_data[i];
          out_last[o]  = in_last[i];
          out_meta[o]  = in_meta[i];
        end
      end
      arb_done[o] = out_valid[o] && out_ready[o] && out_last[o];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pxb_out_arb #(.N_IN(N_IN)) u_arb (
      .clk(clk), .rst(rst), .req(arb_req[o]), .room(out_room[o]),
      .done(arb_done[o]), .busy(arb_busy[o]), .owner(arb_owner[o])
    );
  end
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int IW   = pxb_pkg::idx_w(N_IN)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_IN-1:0]         in_valid,
  input logic [N_IN-1:0]         in_ready,
  input logic [N_OUT-1:0]        out_valid,
  input logic [N_OUT-1:0]        out_ready,
  input logic [N_OUT-1:0]        out_last,
  input logic [N_OUT-1:0]        out_room,
  input logic [N_OUT-1:0]        busy,
  input logic [N_OUT-1:0][IW-1:0] owner
);
  logic [N_IN-1:0][N_OUT-1:0] own_mask;

  always_comb begin
    for (int i = 0; i < N_IN; i++)
      for (int o = 0; o < N_OUT; o++)
        own_mask[i][o] = busy[o] && owner[o] == IW'(i);
  end

  // R1
  beat_balance_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(in_valid & in_ready) == $countones(out_valid & out_ready));

  // R2
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && in_ready == '0));

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    // R5
    room_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy[o]) |-> $past(out_room[o]));
    // R6
    hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (busy[o] && !(out_valid[o] && out_ready[o] && out_last[o]))
      |=> (busy[o] && $stable(owner[o])));
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_i
    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(own_mask[i]));
  end
endmodule

bind pkt_xbar pxb_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_room(out_room), .busy(arb_busy), .owner(arb_owner)
);

// File: tb/pkt_xbar_tb.sv
module pkt_xbar_tb;
  localparam int NI = 3, NO = 3, DW = 16, IW = 2, DSTW = 2;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [IW-1:0] cfg_addr = '0;
  logic [DSTW:0] cfg_wdata = '0;
  logic [NI-1:0][DW-1:0] in_data = '0;
  logic [NI-1:0] in_valid = '0, in_last = '0, in_meta = '0, in_ready;
  logic [NO-1:0][DW-1:0] out_data;
  logic [NO-1:0] out_valid, out_last, out_meta;
  logic [NO-1:0] out_ready = '1, out_room = '1;

  always #2.5 clk = ~clk;

  pkt_xbar #(.N_IN(NI), .N_OUT(NO), .DW(DW)) u_dut (.*);

  typedef struct { logic [DW-1:0] d; logic m; logic l; int dst; } beat_t;
  beat_t exp_q[NI][$];
  int checks = 0, errors = 0;
  int beats[NO];
  bit mid[NO];
  int cur[NO];
  int start_log[$];
  int pkt_id[NI];
  bit rdy_rand = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // output monitor: R1, R6, R7, R9
  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < NO; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          int src;
          beat_t e;
          src = int'(out_data[o][15:14]);
          if (mid[o]) chk(src == cur[o], "R6 interleave", src, cur[o]);
          if (src >= NI || exp_q[src].size() == 0) begin
            chk(0, "R9 unexpected beat", int'(out_data[o]), -1);
          end else begin
            e = exp_q[src].pop_front();
            chk(e.d == out_data[o], "R9 data", int'(out_data[o]), int'(e.d));
            chk(e.m == out_meta[o], "R1 meta", int'(out_meta[o]), int'(e.m));
            chk(e.l == out_last[o], "R1 last", int'(out_last[o]), int'(e.l));
            chk(e.dst == o, "R9/R7 destination", o, e.dst);
          end
          if (!mid[o] && o == 0) start_log.push_back(src);
          mid[o] = !out_last[o];
          cur[o] = src;
          beats[o]++;
        end
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = rdy_rand ? NO'($urandom) : '1;
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg_write(int a, bit en, int dst);
    cfg_we = 1; cfg_addr = IW'(a); cfg_wdata = {en, DSTW'(dst)};
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic send_pkt(int i, int len, int dst, bit gaps);
    for (int b = 0; b < len; b++) begin
      beat_t e;
      if (gaps && b > 0) cyc($urandom % 3);
      e.d = {2'(i), 6'(pkt_id[i]), 8'(b)};
      e.m = 1'($urandom);
      e.l = (b == len - 1);
      e.dst = dst;
      in_data[i] = e.d; in_meta[i] = e.m; in_last[i] = e.l; in_valid[i] = 1;
      exp_q[i].push_back(e);
      do @(negedge clk); while (!in_ready[i]);
      cyc(1);
      in_valid[i] = 0;
    end
    pkt_id[i]++;
  endtask

  task automatic drain(string req);
    cyc(20);
    for (int i = 0; i < NI; i++)
      chk(exp_q[i].size() == 0, req, exp_q[i].size(), 0);
  endtask

  // R2, R4: nothing moves before any route is written
  task automatic t_reset();
    chk(out_valid == '0, "R2 out_valid", int'(out_valid), 0);
    chk(in_ready == '0, "R2 in_ready", int'(in_ready), 0);
    in_valid = '1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(in_ready == '0 && out_valid == '0, "R4 disabled route",
          int'(in_ready), 0);
      cyc(1);
    end
    in_valid = '0;
  endtask

  // R4 invalid destination, R3 out-of-range address
  task automatic t_invalid();
    int b0;
    cfg_write(0, 1, 3);
    cfg_write(3, 1, 0);
    b0 = beats[0] + beats[1] + beats[2];
    in_valid[0] = 1; in_data[0] = 16'h0fff;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!in_ready[0], "R4 invalid dest ready", int'(in_ready[0]), 0);
      cyc(1);
    end
    chk(beats[0] + beats[1] + beats[2] == b0, "R3 R4 no forwarding",
        beats[0] + beats[1] + beats[2], b0);
    in_valid[0] = 0;
  endtask

  // R1, R3, R9: three disjoint routes, random gaps both sides
  task automatic t_basic();
    cfg_write(0, 1, 1);
    cfg_write(1, 1, 0);
    cfg_write(2, 1, 2);
    rdy_rand = 1;
    fork
      for (int p = 0; p < 4; p++) send_pkt(0, 1 + $urandom % 5, 1, 1);
      for (int p = 0; p < 4; p++) send_pkt(1, 1 + $urandom % 5, 0, 1);
      for (int p = 0; p < 4; p++) send_pkt(2, 1 + $urandom % 5, 2, 1);
    join
    rdy_rand = 0;
    drain("R9 basic drained");
  endtask

  // R5: no start while room is low
  task automatic t_room();
    int b0;
    cfg_write(1, 1, 0);
    out_room[0] = 0;
    b0 = beats[0];
    fork send_pkt(1, 3, 0, 0); join_none
    cyc(15);
    chk(beats[0] == b0, "R5 start without room", beats[0], b0);
    out_room[0] = 1;
    wait fork;
    cyc(5);
    chk(beats[0] == b0 + 3, "R5 after room", beats[0], b0 + 3);
    drain("R5 drained");
  endtask

  // R8: three inputs contend for output 0
  task automatic t_contend();
    for (int i = 0; i < NI; i++) cfg_write(i, 1, 0);
    start_log.delete();
    rdy_rand = 1;
    fork
      for (int p = 0; p < 2; p++) send_pkt(0, 1 + $urandom % 4, 0, 1);
      for (int p = 0; p < 2; p++) send_pkt(1, 1 + $urandom % 4, 0, 1);
      for (int p = 0; p < 2; p++) send_pkt(2, 1 + $urandom % 4, 0, 1);
    join
    rdy_rand = 0;
    drain("R9 contend drained");
    chk(start_log.size() == 6, "R8 packet count", start_log.size(), 6);
    for (int k = 0; k + 1 < start_log.size(); k++)
      chk(start_log[k+1] == (start_log[k] + 1) % NI, "R8 rotation",
          start_log[k+1], (start_log[k] + 1) % NI);
  endtask

  // R7: re-route in mid-packet
  task automatic t_reroute();
    int b1;
    cfg_write(0, 1, 1);
    b1 = beats[1];
    fork
      send_pkt(0, 8, 1, 1);
      begin
        wait (beats[1] >= b1 + 2);
        cyc(1);
        cfg_write(0, 1, 2);
      end
    join
    chk(beats[1] == b1 + 8, "R7 packet stayed", beats[1], b1 + 8);
    send_pkt(0, 3, 2, 0);
    drain("R7 drained");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_basic();
    t_room();
    t_contend();
    t_reroute();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule